// File: doc/BRIEF.md
# Root Clock Generator with Fractional Divider

This block builds a derived clock from one of several source clocks. Each source is represented by an enable strobe, and all strobes are timed by one common reference. The generator picks one strobe and passes it through an integer pre-divider. It can then pass the result through a fractional M/N stage, whose duty cycle is set by a separate D value. The outputs are a one-cycle tick per derived clock period (`out_tick_o`) and a level (`clk_out_o`) that carries the duty cycle.

Software writes staged copies of the configuration through a simple write port: the source/divider/mode word, M, N and D. None of these writes changes the output until an update command is written. The update status reads high from the cycle after that command until the staged values have been copied into the live set. The copy happens only on a derived clock boundary. A separate table holds one complete configuration per performance level. When the table-driven mode is on, an update loads the level named by `perf_idx_i`. After that, any change of the index starts a switch without a new command.

A small state machine sequences every switch:
- ST_RUN →(update command, or index change in table mode)→ ST_WAIT
- ST_WAIT →(boundary)→ ST_COMMIT
- ST_COMMIT → ST_RUN, or → ST_WAIT if another update command arrives during the commit cycle

Top module: `rcg_mnd_top`

## Requirements
- R1: After reset the update status is low, source 0 is active with divide-by-one and the fractional stage is off, so `out_tick_o` and `clk_out_o` pulse once for every `src_en_i[0]` strobe.
- R2: The integer divider field is bits [4:0] of the word at address 0. A value of v ≥ 2 gives one pre-divided tick per v selected strobes. Values 0 and 1 both mean divide by one.
- R3: The source field is bits [10:8] of the word at address 0 and selects `src_en_i[src]`. A value of NSRC or more selects no source: no ticks appear, and a later update still completes.
- R4: Writes to addresses 0–3 and to table entries do not change the outputs until an update command commits them.
- R5: Writing address 4 with bit 0 set raises `upd_busy_o` in the next cycle. It falls exactly two cycles after an `out_tick_o` pulse, or two cycles after any cycle when the live source is out of range.
- R6: M is at address 1, the N word at address 2 holds ~(N−M), and the D word at address 3 holds ~(2·D), all within MNDW bits. With M ≠ 0 and mode field bits [13:12] = 2'b10 (dual-edge), the block gives M output ticks per N pre-divided ticks.
- R7: In fractional mode an accumulator starts at 0 on commit, adds M modulo N on each pre-divided tick, and `clk_out_o` is high while the accumulator is below D.
- R8: With M = 0, or with any mode other than 2'b10, the fractional stage is bypassed and `clk_out_o` equals the pre-divided tick pulse.
- R9: Table level L uses addresses 8+4L (word), 9+4L (M), 10+4L (N), 11+4L (D). Bit 1 of the address-4 write selects table-driven control, and a commit in that mode loads the level named by `perf_idx_i`.
- R10: Once a table level is live and table mode is still on, a change of `perf_idx_i` raises `upd_busy_o` without a command and switches to the new level.
- R11: `out_tick_o` is only high in a cycle that follows a cycle with at least one source strobe.
- R12: In the cycle after a commit, `out_tick_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_en_i | input | NSRC | Per-source clock strobes |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | DW | Register write data |
| perf_idx_i | input | LVLW | Performance level index |
| out_tick_o | output | 1 | One pulse per derived clock period |
| clk_out_o | output | 1 | Derived clock level carrying the duty cycle |
| upd_busy_o | output | 1 | Update pending status |

## Verification
A wrong live setting shows up at the ports as a wrong count of ticks or high cycles over one full derived period. A period is at most source-period × divider × N reference cycles, so the error is visible within that time after `upd_busy_o` falls. A sequencer fault shows up sooner, within a cycle or two: the status rises late, falls with no preceding boundary, or a tick appears on the commit cycle. A lost staging copy shows up as a change in rate before any update command is written.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
    localparam int CFG_DIV_LSB  = 0;
    localparam int CFG_DIV_W    = 5;
    localparam int CFG_SRC_LSB  = 8;
    localparam int CFG_SRC_W    = 3;
    localparam int CFG_MODE_LSB = 12;
    localparam int CFG_MODE_W   = 2;

    localparam logic [CFG_MODE_W-1:0] MODE_DUAL = 2'b10;

    localparam int ADR_CFG = 0;
    localparam int ADR_M   = 1;
    localparam int ADR_N   = 2;
    localparam int ADR_D   = 3;
    localparam int ADR_CMD = 4;
    localparam int ADR_TBL = 8;

    localparam int CMD_UPD_BIT = 0;
    localparam int CMD_TBL_BIT = 1;

    typedef struct packed {
        logic [CFG_MODE_W-1:0] mode;
        logic [CFG_SRC_W-1:0]  src;
        logic [CFG_DIV_W-1:0]  div;
    } cfg_word_t;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_WAIT   = 2'd1,
        ST_COMMIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/rcg_regs.sv
module rcg_regs
    import rcg_pkg::*;
#(
    parameter int DW     = 16,
    parameter int MNDW   = 8,
    parameter int LEVELS = 4,
    parameter int AW     = 5,
    parameter int LVLW   = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic [DW-1:0]   wr_data_i,
    input  logic [LVLW-1:0] perf_idx_i,
    output cfg_word_t       sh_cfg_o,
    output logic [MNDW-1:0] sh_m_o,
    output logic [MNDW-1:0] sh_n_o,
    output logic [MNDW-1:0] sh_d_o,
    output cfg_word_t       tb_cfg_o,
    output logic [MNDW-1:0] tb_m_o,
    output logic [MNDW-1:0] tb_n_o,
    output logic [MNDW-1:0] tb_d_o,
    output logic            tbl_mode_o,
    output logic            upd_req_o
);
    cfg_word_t       cfg_in;
    logic [MNDW-1:0] val_in;
    logic            unused_wdata;

    assign cfg_in.div  = wr_data_i[CFG_DIV_LSB  +: CFG_DIV_W];
    assign cfg_in.src  = wr_data_i[CFG_SRC_LSB  +: CFG_SRC_W];
    assign cfg_in.mode = wr_data_i[CFG_MODE_LSB +: CFG_MODE_W];
    assign val_in      = wr_data_i[MNDW-1:0];
    assign unused_wdata = ^wr_data_i;

    function automatic logic hit(input logic [AW-1:0] a, input int target);
        return a == AW'(target);
    endfunction

    assign upd_req_o = wr_en_i && hit(wr_addr_i, ADR_CMD) && wr_data_i[CMD_UPD_BIT];

    // staged single configuration and control bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_cfg_o   <= '0;
            sh_m_o     <= '0;
            sh_n_o     <= '0;
            sh_d_o     <= '0;
            tbl_mode_o <= 1'b0;
        end else if (wr_en_i) begin
            if (hit(wr_addr_i, ADR_CFG)) sh_cfg_o <= cfg_in;
            if (hit(wr_addr_i, ADR_M))   sh_m_o   <= val_in;
            if (hit(wr_addr_i, ADR_N))   sh_n_o   <= val_in;
            if (hit(wr_addr_i, ADR_D))   sh_d_o   <= val_in;
            if (hit(wr_addr_i, ADR_CMD)) tbl_mode_o <= wr_data_i[CMD_TBL_BIT];
        end
    end

    cfg_word_t       lvl_cfg [LEVELS];
    logic [MNDW-1:0] lvl_m   [LEVELS];
    logic [MNDW-1:0] lvl_n   [LEVELS];
    logic [MNDW-1:0] lvl_d   [LEVELS];

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
        localparam int BASE = ADR_TBL + 4 * lv;
        cfg_word_t       r_cfg;
        logic [MNDW-1:0] r_m, r_n, r_d;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                r_cfg <= '0;
                r_m   <= '0;
                r_n   <= '0;
                r_d   <= '0;
            end else if (wr_en_i) begin
                if (hit(wr_addr_i, BASE))     r_cfg <= cfg_in;
                if (hit(wr_addr_i, BASE + 1)) r_m   <= val_in;
                if (hit(wr_addr_i, BASE + 2)) r_n   <= val_in;
                if (hit(wr_addr_i, BASE + 3)) r_d   <= val_in;
            end
        end

        assign lvl_cfg[lv] = r_cfg;
        assign lvl_m[lv]   = r_m;
        assign lvl_n[lv]   = r_n;
        assign lvl_d[lv]   = r_d;
    end

    assign tb_cfg_o = lvl_cfg[perf_idx_i];
    assign tb_m_o   = lvl_m[perf_idx_i];
    assign tb_n_o   = lvl_n[perf_idx_i];
    assign tb_d_o   = lvl_d[perf_idx_i];
endmodule

// File: rtl/rcg_seq.sv
module rcg_seq
    import rcg_pkg::*;
#(
    parameter int MNDW = 8,
    parameter int LVLW = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 upd_req_i,
    input  logic                 tbl_mode_i,
    input  logic [LVLW-1:0]      perf_idx_i,
    input  logic                 boundary_i,
    input  cfg_word_t            sh_cfg_i,
    input  logic [MNDW-1:0]      sh_m_i,
    input  logic [MNDW-1:0]      sh_n_i,
    input  logic [MNDW-1:0]      sh_d_i,
    input  cfg_word_t            tb_cfg_i,
    input  logic [MNDW-1:0]      tb_m_i,
    input  logic [MNDW-1:0]      tb_n_i,
    input  logic [MNDW-1:0]      tb_d_i,
    output logic [CFG_SRC_W-1:0] act_src_o,
    output logic [CFG_DIV_W-1:0] act_div_o,
    output logic                 act_mnd_o,
    output logic [MNDW-1:0]      act_m_o,
    output logic [MNDW-1:0]      act_n_o,
    output logic [MNDW-1:0]      act_d2_o,
    output logic                 commit_o,
    output logic                 busy_o
);
    seq_state_e state_q, state_d;
    logic [LVLW-1:0] loaded_idx_q;
    logic            from_tbl_q;
    logic            auto_req;

    assign auto_req = tbl_mode_i && from_tbl_q && (perf_idx_i != loaded_idx_q);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (upd_req_i || auto_req) state_d = ST_WAIT;
            ST_WAIT:   if (boundary_i)            state_d = ST_COMMIT;
            ST_COMMIT: state_d = upd_req_i ? ST_WAIT : ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_RUN;
        else         state_q <= state_d;
    end

    // outputs of the sequencer
    always_comb begin
        commit_o = 1'b0;
        busy_o   = 1'b1;
        unique case (state_q)
            ST_RUN:    busy_o   = 1'b0;
            ST_WAIT:   busy_o   = 1'b1;
            ST_COMMIT: commit_o = 1'b1;
            default:   busy_o   = 1'b0;
        endcase
    end

    // pick the staged or table set and decode it
    cfg_word_t       pick_cfg;
    logic [MNDW-1:0] pick_m, pick_n, pick_d;

    always_comb begin
        if (tbl_mode_i) begin
            pick_cfg = tb_cfg_i;
            pick_m   = tb_m_i;
            pick_n   = tb_n_i;
            pick_d   = tb_d_i;
        end else begin
            pick_cfg = sh_cfg_i;
            pick_m   = sh_m_i;
            pick_n   = sh_n_i;
            pick_d   = sh_d_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            act_src_o    <= '0;
            act_div_o    <= CFG_DIV_W'(1);
            act_mnd_o    <= 1'b0;
            act_m_o      <= '0;
            act_n_o      <= '0;
            act_d2_o     <= '0;
            loaded_idx_q <= '0;
            from_tbl_q   <= 1'b0;
        end else if (commit_o) begin
            act_src_o    <= pick_cfg.src;
            act_div_o    <= (pick_cfg.div < CFG_DIV_W'(2)) ? CFG_DIV_W'(1) : pick_cfg.div;
            act_mnd_o    <= (pick_m != '0) && (pick_cfg.mode == MODE_DUAL);
            act_m_o      <= pick_m;
            act_n_o      <= ~pick_n + pick_m;
            act_d2_o     <= ~pick_d;
            loaded_idx_q <= perf_idx_i;
            from_tbl_q   <= tbl_mode_i;
        end
    end
endmodule

// File: rtl/rcg_divider.sv
module rcg_divider
    import rcg_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int MNDW = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 commit_i,
    input  logic [NSRC-1:0]      src_en_i,
    input  logic [CFG_SRC_W-1:0] src_i,
    input  logic [CFG_DIV_W-1:0] div_i,
    input  logic                 mnd_i,
    input  logic [MNDW-1:0]      m_i,
    input  logic [MNDW-1:0]      n_i,
    input  logic [MNDW-1:0]      d2_i,
    output logic                 out_tick_o,
    output logic                 clk_out_o
);
    logic                 sel_tick, pre_tick, wrap;
    logic [CFG_DIV_W-1:0] dcnt_q;
    logic [MNDW-1:0]      acc_q, acc_nx;
    logic [MNDW:0]        sum;

    always_comb begin
        sel_tick = 1'b0;
        for (int s = 0; s < NSRC; s++)
            if (src_i == CFG_SRC_W'(s)) sel_tick = src_en_i[s];
    end

    assign pre_tick = sel_tick && (dcnt_q == div_i - CFG_DIV_W'(1));

    // integer pre-divider
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       dcnt_q <= '0;
        else if (commit_i) dcnt_q <= '0;
        else if (sel_tick) dcnt_q <= pre_tick ? '0 : dcnt_q + CFG_DIV_W'(1);
    end

    // fractional accumulator, modulo N
    assign sum    = {1'b0, acc_q} + {1'b0, m_i};
    assign wrap   = sum >= {1'b0, n_i};
    assign acc_nx = wrap ? MNDW'(sum - {1'b0, n_i}) : sum[MNDW-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 acc_q <= '0;
        else if (commit_i)           acc_q <= '0;
        else if (pre_tick && mnd_i)  acc_q <= acc_nx;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_tick_o <= 1'b0;
            clk_out_o  <= 1'b0;
        end else if (commit_i) begin
            out_tick_o <= 1'b0;
            clk_out_o  <= 1'b0;
        end else if (mnd_i) begin
            out_tick_o <= pre_tick && wrap;
            if (pre_tick) clk_out_o <= {acc_nx, 1'b0} < {1'b0, d2_i};
        end else begin
            out_tick_o <= pre_tick;
            clk_out_o  <= pre_tick;
        end
    end
endmodule

// File: rtl/rcg_mnd_top.sv
module rcg_mnd_top
    import rcg_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int MNDW   = 8,
    parameter int LEVELS = 4,
    parameter int DW     = 16,
    parameter int AW     = $clog2(ADR_TBL + 4 * LEVELS),
    parameter int LVLW   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] src_en_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic [DW-1:0]   wr_data_i,
    input  logic [LVLW-1:0] perf_idx_i,
    output logic            out_tick_o,
    output logic            clk_out_o,
    output logic            upd_busy_o
);
    cfg_word_t            sh_cfg, tb_cfg;
    logic [MNDW-1:0]      sh_m, sh_n, sh_d, tb_m, tb_n, tb_d;
    logic                 tbl_mode, upd_req, commit, boundary, src_bad;
    logic [CFG_SRC_W-1:0] act_src;
    logic [CFG_DIV_W-1:0] act_div;
    logic                 act_mnd;
    logic [MNDW-1:0]      act_m, act_n, act_d2;

    assign src_bad  = act_src >= CFG_SRC_W'(NSRC);
    assign boundary = out_tick_o || src_bad;

    rcg_regs #(
        .DW(DW), .MNDW(MNDW), .LEVELS(LEVELS), .AW(AW), .LVLW(LVLW)
    ) i_regs (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .perf_idx_i(perf_idx_i),
        .sh_cfg_o(sh_cfg), .sh_m_o(sh_m), .sh_n_o(sh_n), .sh_d_o(sh_d),
        .tb_cfg_o(tb_cfg), .tb_m_o(tb_m), .tb_n_o(tb_n), .tb_d_o(tb_d),
        .tbl_mode_o(tbl_mode), .upd_req_o(upd_req)
    );

    rcg_seq #(.MNDW(MNDW), .LVLW(LVLW)) i_seq (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .upd_req_i(upd_req), .tbl_mode_i(tbl_mode), .perf_idx_i(perf_idx_i),
        .boundary_i(boundary),
        .sh_cfg_i(sh_cfg), .sh_m_i(sh_m), .sh_n_i(sh_n), .sh_d_i(sh_d),
        .tb_cfg_i(tb_cfg), .tb_m_i(tb_m), .tb_n_i(tb_n), .tb_d_i(tb_d),
        .act_src_o(act_src), .act_div_o(act_div), .act_mnd_o(act_mnd),
        .act_m_o(act_m), .act_n_o(act_n), .act_d2_o(act_d2),
        .commit_o(commit), .busy_o(upd_busy_o)
    );

    rcg_divider #(.NSRC(NSRC), .MNDW(MNDW)) i_div (
        .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit),
        .src_en_i(src_en_i), .src_i(act_src), .div_i(act_div),
        .mnd_i(act_mnd), .m_i(act_m), .n_i(act_n), .d2_i(act_d2),
        .out_tick_o(out_tick_o), .clk_out_o(clk_out_o)
    );
endmodule

// File: rtl/rcg_mnd_chk.sv
module rcg_mnd_chk
    import rcg_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int AW   = 5,
    parameter int DW   = 16
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [NSRC-1:0] src_en_i,
    input logic            wr_en_i,
    input logic [AW-1:0]   wr_addr_i,
    input logic [DW-1:0]   wr_data_i,
    input logic            out_tick_o,
    input logic            upd_busy_o,
    input logic            src_bad
);
    // R5: an update command raises the status in the next cycle
    a_r5_busy_on_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == AW'(ADR_CMD) && wr_data_i[CMD_UPD_BIT]) |=> upd_busy_o);

    // R5: the status only clears two cycles after a boundary
    a_r5_clear_after_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(upd_busy_o) |-> ($past(out_tick_o, 2) || $past(src_bad, 2)));

    // R11: a tick needs a source strobe in the cycle before
    a_r11_tick_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_tick_o |-> $past(|src_en_i));

    // R12: no tick right after a commit
    a_r12_quiet_after_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(upd_busy_o) |-> !out_tick_o);
endmodule

bind rcg_mnd_top rcg_mnd_chk #(.NSRC(NSRC), .AW(AW), .DW(DW)) i_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_en_i(src_en_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .out_tick_o(out_tick_o), .upd_busy_o(upd_busy_o), .src_bad(src_bad)
);

// File: tb/test_rcg_mnd_top.sv
module test_rcg_mnd_top;
    localparam int NSRC = 4;
    localparam int AW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_en = '0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [15:0]     wr_data = '0;
    logic [1:0]      perf_idx = '0;
    logic            out_tick, clk_out, busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {int src; int div; int mode; int m; int n; int d;} bcfg_t;

    rcg_mnd_top i_rcg_mnd_top (
        .clk_i(clk), .rst_ni(rst_n), .src_en_i(src_en),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .perf_idx_i(perf_idx),
        .out_tick_o(out_tick), .clk_out_o(clk_out), .upd_busy_o(busy)
    );

    always #10 clk = ~clk;

    // source i strobes once every i+1 reference cycles
    initial begin
        int ph [NSRC];
        for (int i = 0; i < NSRC; i++) ph[i] = 0;
        forever begin
            @(posedge clk); #2;
            for (int i = 0; i < NSRC; i++) begin
                ph[i] = (ph[i] >= i) ? 0 : ph[i] + 1;
                src_en[i] = (ph[i] == 0);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = a[AW-1:0]; wr_data = d[15:0];
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic prog(input int base, input bcfg_t c);
        wr(base,     (c.div & 31) | ((c.src & 7) << 8) | ((c.mode & 3) << 12));
        wr(base + 1, c.m & 255);
        wr(base + 2, (~(c.n - c.m)) & 255);
        wr(base + 3, (~(2 * c.d)) & 255);
    endtask

    function automatic bit is_frac(input bcfg_t c);
        return c.m != 0 && c.mode == 2;
    endfunction

    // period in reference cycles, ticks and high cycles per period
    function automatic void expect_cfg(input bcfg_t c, output int per, output int tk, output int hi);
        int sp = c.src + 1;
        int de = (c.div < 2) ? 1 : c.div;
        if (c.src >= NSRC) begin
            per = 50; tk = 0; hi = 0;
        end else if (is_frac(c)) begin
            int cnt = 0;
            for (int j = 0; j < c.n; j++) if (((j * c.m) % c.n) < c.d) cnt++;
            per = sp * de * c.n; tk = c.m; hi = sp * de * cnt;
        end else begin
            per = sp * de; tk = 1; hi = 1;
        end
    endfunction

    task automatic measure(input bcfg_t c, input string req);
        int per, tk, hi, ct = 0, ch = 0;
        expect_cfg(c, per, tk, hi);
        repeat (per + 2) @(negedge clk);
        repeat (2 * per) begin
            @(negedge clk);
            ct += int'(out_tick);
            ch += int'(clk_out);
        end
        chk(ct == 2 * tk, {req, " ticks"}, ct, 2 * tk);
        chk(ch == 2 * hi, {req, " high cycles"}, ch, 2 * hi);
    endtask

    // commit and check the status timing (R5)
    task automatic commit(input bit tbl, input bit old_bad);
        bit h1 = 0, h2 = 0;
        int k = 0;
        wr(4, tbl ? 3 : 1);
        @(negedge clk);
        chk(busy == 1'b1, "R5 status after command", int'(busy), 1);
        h1 = out_tick;
        while (busy && k < 3000) begin
            @(negedge clk);
            k++;
            if (busy) begin h2 = h1; h1 = out_tick; end
        end
        chk(!busy, "R5 status clears", int'(busy), 0);
        if (!old_bad) chk(h2 == 1'b1, "R5 clear two cycles after tick", int'(h2), 1);
        chk(out_tick == 1'b0, "R12 no tick after commit", int'(out_tick), 0);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bcfg_t c, a, b;
        bcfg_t lv [4];
        int cnt;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(busy == 1'b0, "R1 status after reset", int'(busy), 0);
        c = '{0, 1, 0, 0, 1, 0};
        measure(c, "R1 reset config");

        // R2 divider values 0 and 1 both divide by one, 5 divides by five
        c = '{0, 0, 0, 0, 1, 0};  prog(0, c); commit(0, 0); measure(c, "R2 div 0");
        c = '{0, 5, 0, 0, 1, 0};  prog(0, c); commit(0, 0); measure(c, "R2 div 5");

        // R4 staged writes have no effect before the command
        a = c;
        b = '{2, 3, 2, 3, 7, 3};
        prog(0, b);
        measure(a, "R4 old rate kept");
        commit(0, 0);
        measure(b, "R6 after commit");

        // R3 source out of range, then recovery
        c = '{5, 1, 0, 0, 1, 0};  prog(0, c); commit(0, 0); measure(c, "R3 no source");
        c = '{3, 2, 0, 0, 1, 0};  prog(0, c); commit(0, 1); measure(c, "R3 source 3");

        // R8 M nonzero but not dual-edge
        c = '{1, 2, 1, 3, 8, 4};  prog(0, c); commit(0, 0); measure(c, "R8 bypass mode");
        // R7 duty extremes
        c = '{0, 1, 2, 3, 8, 0};  prog(0, c); commit(0, 0); measure(c, "R7 duty zero");
        c = '{0, 1, 2, 5, 9, 9};  prog(0, c); commit(0, 0); measure(c, "R7 duty full");

        // R9 table levels, R10 index change
        lv[0] = '{0, 1, 2, 1, 3, 1};
        lv[1] = '{1, 3, 0, 0, 1, 0};
        lv[2] = '{2, 2, 2, 3, 10, 6};
        lv[3] = '{0, 4, 2, 2, 5, 2};
        for (int l = 0; l < 4; l++) prog(8 + 4 * l, lv[l]);
        @(posedge clk); #2 perf_idx = 2'd2;
        commit(1, 0);
        measure(lv[2], "R9 table level 2");
        @(posedge clk); #2 perf_idx = 2'd1;
        cnt = 0;
        repeat (3) begin @(negedge clk); cnt += int'(busy); end
        chk(cnt > 0, "R10 index change starts switch", cnt, 1);
        cnt = 0;
        while (busy && cnt < 3000) begin @(negedge clk); cnt++; end
        measure(lv[1], "R10 table level 1");
        @(posedge clk); #2 perf_idx = 2'd3;
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        measure(lv[3], "R10 table level 3");
        // back to the staged set
        c = '{1, 2, 2, 2, 7, 3};  prog(0, c); commit(0, 0); measure(c, "R9 leave table");

        // random configurations
        for (int it = 0; it < 16; it++) begin
            c.src  = $urandom % NSRC;
            c.div  = $urandom % 6;
            c.mode = ($urandom % 5 == 0) ? 1 : 2;
            c.n    = 2 + $urandom % 11;
            c.m    = ($urandom % 4 == 0) ? 0 : 1 + $urandom % (c.n - 1);
            c.d    = $urandom % (c.n + 1);
            prog(0, c);
            commit(0, 0);
            measure(c, is_frac(c) ? "R6 R7 random fractional" : "R2 R8 random bypass");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule